// File: doc/BRIEF.md
# SerDes Lane Override Sequencer

This block walks one physical-layer lane through a fixed series of register read-modify-write steps that force the lane's receive clock-recovery mode and, optionally, its transmit attenuation. It does not touch the lane registers itself. Every access leaves through a request port: address, write flag and write data, held until the access engine accepts it. Read data comes back on a separate response strobe. The block waits for each read response before it issues the next request.

A start command first polls the lane's receive status until the half-rate indication drops, with a bounded number of extra polls. It then clears, sets and programs the receive override word, pulses the DPLL reset bit and waits a settle time. Unless the attenuation value says to skip it, the block then programs the transmit override word in the same clear, set, then insert-field manner. A clear command performs only one step: it reads the receive status and writes it back to the receive override register with the override enable cleared. The block pulses `done` once at the end of either command.

Top module: `lane_ovr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `req_valid` are low.
- R2: A start command begins by reading RX status at 0x2002 + lane*0x100. While bit 0 of the returned word is 1, the block reads the same register again, up to 1000 extra reads, so it makes at most 1001 polling reads.
- R3: After polling, the block reads RX status once more, giving word r. It then makes five writes to 0x2005 + lane*0x100, in this order:
  - w0 = r with bit 14 cleared;
  - w1 = w0 with bit 14 set;
  - w2 = w1 with bits 10:8 replaced by the DPLL mode (3);
  - w3 = w2 with bit 11 set;
  - w4 = w3 with bit 11 cleared.
- R4: From the acceptance of w4, the block issues no request for at least SETTLE_CYCLES cycles.
- R5: If bit 3 of the attenuation value is 0, the block then reads TX status at 0x2001 + lane*0x100, giving word t. It then makes three writes to 0x2004 + lane*0x100:
  - v0 = t with bit 15 cleared;
  - v1 = v0 with bit 15 set;
  - v2 = v1 OR (attenuation[2:0] << 10).

  If bit 3 of the attenuation value is 1, the block makes no TX access at all.
- R6: A clear command makes exactly one read of RX status, followed by one write to the RX override register. The write carries the returned word with bit 14 cleared.
- R7: `busy` is high from the cycle after a command until the command ends. `done` is high for exactly one cycle per command. When the command ends on a write, `done` is high in the cycle right after that final write is accepted.
- R8: Commands that arrive while `busy` is high are ignored. The lane and attenuation values are captured when a command is accepted. If start and clear arrive together, start wins.
- R9: A pending request keeps its address, direction and data unchanged until `req_ready` accepts it. No new request is raised while a read response is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Start the full override sequence |
| clear_cmd | input | 1 | Start the receive-override clear |
| lane_sel | input | LANE_W | Lane index for the command |
| atten_val | input | 4 | Transmit attenuation; bit 3 set skips the transmit step |
| req_valid | output | 1 | Register access request pending |
| req_write | output | 1 | 1 for a write, 0 for a read |
| req_addr | output | ADDR_W | Register address |
| req_wdata | output | DATA_W | Write data |
| req_ready | input | 1 | Engine accepts the pending request |
| rsp_valid | input | 1 | Read data is valid |
| rsp_rdata | input | DATA_W | Read data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The hardest situation to reach is the polling bound: the lane must report half-rate on every read long enough to use up all 1000 extra polls. The bench's register model drives this with a per-run count of half-rate answers. It sets that count above the bound and then checks two things: the number of polling reads, and that the words written afterwards still carry the half-rate bit from the last read. A second hard case is a command arriving mid-sequence. The bench pokes start and clear with a different lane while the engine stalls every other cycle, then checks that every address still belongs to the captured lane.

// File: rtl/lovr_pkg.sv
package lovr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL, ST_RX_RD, ST_RX_WR, ST_SETTLE,
    ST_TX_RD, ST_TX_WR, ST_CLR_RD, ST_CLR_WR
  } st_e;

  typedef enum logic [1:0] {
    TGT_RX_STS, TGT_TX_STS, TGT_RX_OVR, TGT_TX_OVR
  } tgt_e;

  localparam logic [15:0] LANE_STRIDE  = 16'h0100;
  localparam logic [15:0] BASE_RX_STS  = 16'h2002;
  localparam logic [15:0] BASE_TX_STS  = 16'h2001;
  localparam logic [15:0] BASE_RX_OVR  = 16'h2005;
  localparam logic [15:0] BASE_TX_OVR  = 16'h2004;

  localparam int HALF_RATE_BIT = 0;
  localparam int RX_FORCE_BIT  = 14;
  localparam int TX_FORCE_BIT  = 15;
  localparam int DPLL_RST_BIT  = 11;
  localparam int DPLL_LSB      = 8;
  localparam int DPLL_W        = 3;
  localparam int ATT_LSB       = 10;
  localparam int ATT_W         = 3;
  localparam int SKIP_BIT      = 3;

  function automatic tgt_e target_of(st_e s);
    case (s)
      ST_TX_RD:             target_of = TGT_TX_STS;
      ST_RX_WR, ST_CLR_WR:  target_of = TGT_RX_OVR;
      ST_TX_WR:             target_of = TGT_TX_OVR;
      default:              target_of = TGT_RX_STS;
    endcase
  endfunction

  function automatic logic [2:0] last_write(st_e s);
    case (s)
      ST_RX_WR: last_write = 3'd4;
      ST_TX_WR: last_write = 3'd2;
      default:  last_write = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/lovr_addr.sv
module lovr_addr #(
  parameter int LANE_W = 2,
  parameter int ADDR_W = 16
) (
  input  logic [LANE_W-1:0] lane,
  input  lovr_pkg::tgt_e    tgt,
  output logic [ADDR_W-1:0] addr
);
  import lovr_pkg::*;

  logic [15:0] base;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    case (tgt)
      TGT_TX_STS: base = BASE_TX_STS;
      TGT_RX_OVR: base = BASE_RX_OVR;
      TGT_TX_OVR: base = BASE_TX_OVR;
      default:    base = BASE_RX_STS;
    endcase
  end

  assign offset = ADDR_W'(lane) * ADDR_W'(LANE_STRIDE);
  assign addr   = ADDR_W'(base) + offset;

endmodule

// File: rtl/lovr_timer.sv
module lovr_timer #(
  parameter int SETTLE_CYCLES = 3000000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= CW'(SETTLE_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_load_full_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == CW'(SETTLE_CYCLES)));

endmodule

// File: rtl/lovr_edit.sv
module lovr_edit #(
  parameter int DATA_W    = 16,
  parameter int DPLL_MODE = 3
) (
  input  lovr_pkg::st_e     st,
  input  logic [2:0]        idx,
  input  logic [2:0]        att,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] rsp,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] nxt_word
);
  import lovr_pkg::*;

  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [DATA_W-1:0] RX_FORCE  = ONE << RX_FORCE_BIT;
  localparam logic [DATA_W-1:0] TX_FORCE  = ONE << TX_FORCE_BIT;
  localparam logic [DATA_W-1:0] DPLL_RST  = ONE << DPLL_RST_BIT;
  localparam logic [DATA_W-1:0] DPLL_MASK = DATA_W'((1 << DPLL_W) - 1) << DPLL_LSB;
  localparam logic [DATA_W-1:0] DPLL_VAL  = (DATA_W'(DPLL_MODE) << DPLL_LSB) & DPLL_MASK;

  logic [DATA_W-1:0] att_field;
  assign att_field = DATA_W'(att) << ATT_LSB;

  assign rd_word = (st == ST_TX_RD) ? (rsp & ~TX_FORCE) : (rsp & ~RX_FORCE);

  always_comb begin
    nxt_word = cur;
    if (st == ST_RX_WR) begin
      case (idx)
        3'd0:    nxt_word = cur | RX_FORCE;
        3'd1:    nxt_word = (cur & ~DPLL_MASK) | DPLL_VAL;
        3'd2:    nxt_word = cur | DPLL_RST;
        3'd3:    nxt_word = cur & ~DPLL_RST;
        default: nxt_word = cur;
      endcase
    end else if (st == ST_TX_WR) begin
      case (idx)
        3'd0:    nxt_word = cur | TX_FORCE;
        3'd1:    nxt_word = cur | att_field;
        default: nxt_word = cur;
      endcase
    end
  end

endmodule

// File: rtl/lovr_fsm.sv
module lovr_fsm #(
  parameter int LANE_W          = 2,
  parameter int DATA_W          = 16,
  parameter int MAX_EXTRA_POLLS = 1000,
  parameter int DPLL_MODE       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              clear_cmd,
  input  logic [LANE_W-1:0] lane_in,
  input  logic [3:0]        atten_in,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic              req_valid,
  output logic              req_write,
  output logic [DATA_W-1:0] req_wdata,
  output lovr_pkg::tgt_e    req_tgt,
  output logic [LANE_W-1:0] lane_q,
  output logic              busy,
  output logic              done
);
  import lovr_pkg::*;

  localparam int PCW = $clog2(MAX_EXTRA_POLLS + 1);

  st_e               state;
  logic              pending;
  logic [2:0]        widx;
  logic [DATA_W-1:0] word;
  logic [PCW-1:0]    poll_cnt;
  logic [3:0]        atten_q;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] nxt_word;
  logic              is_read_st;
  logic              is_write_st;
  logic              wr_accept;
  logic              last_wr;

  lovr_edit #(.DATA_W(DATA_W), .DPLL_MODE(DPLL_MODE)) u_edit (
    .st       (state),
    .idx      (widx),
    .att      (atten_q[2:0]),
    .cur      (word),
    .rsp      (rsp_rdata),
    .rd_word  (rd_word),
    .nxt_word (nxt_word)
  );

  assign is_read_st  = (state == ST_POLL) || (state == ST_RX_RD) ||
                       (state == ST_TX_RD) || (state == ST_CLR_RD);
  assign is_write_st = (state == ST_RX_WR) || (state == ST_TX_WR) ||
                       (state == ST_CLR_WR);
  assign wr_accept   = is_write_st && req_valid && req_ready;
  assign last_wr     = (widx == last_write(state));
  assign tmr_load    = wr_accept && last_wr && (state == ST_RX_WR);
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pending   <= 1'b0;
      widx      <= '0;
      word      <= '0;
      poll_cnt  <= '0;
      atten_q   <= '0;
      lane_q    <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_wdata <= '0;
      req_tgt   <= TGT_RX_STS;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start_cmd || clear_cmd) begin
          lane_q   <= lane_in;
          atten_q  <= atten_in;
          poll_cnt <= '0;
          state    <= start_cmd ? ST_POLL : ST_CLR_RD;
        end
      end else if (is_read_st) begin
        if (!req_valid && !pending) begin
          req_valid <= 1'b1;
          req_write <= 1'b0;
          req_tgt   <= target_of(state);
        end else if (req_valid && req_ready) begin
          req_valid <= 1'b0;
          pending   <= 1'b1;
        end else if (pending && rsp_valid) begin
          pending <= 1'b0;
          word    <= rd_word;
          widx    <= '0;
          case (state)
            ST_POLL:
              if (rsp_rdata[HALF_RATE_BIT] && poll_cnt < PCW'(MAX_EXTRA_POLLS))
                poll_cnt <= poll_cnt + 1'b1;
              else
                state <= ST_RX_RD;
            ST_RX_RD: state <= ST_RX_WR;
            ST_TX_RD: state <= ST_TX_WR;
            default:  state <= ST_CLR_WR;
          endcase
        end
      end else if (is_write_st) begin
        if (!req_valid) begin
          req_valid <= 1'b1;
          req_write <= 1'b1;
          req_wdata <= word;
          req_tgt   <= target_of(state);
        end else if (req_ready) begin
          req_valid <= 1'b0;
          word      <= nxt_word;
          widx      <= widx + 1'b1;
          if (last_wr) begin
            if (state == ST_RX_WR) begin
              state <= ST_SETTLE;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
      end else begin
        if (tmr_zero) begin
          if (atten_q[SKIP_BIT]) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_TX_RD;
          end
        end
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);

  p_poll_bound_r2: assert property (@(posedge clk) disable iff (rst)
    poll_cnt <= PCW'(MAX_EXTRA_POLLS));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_lane_held_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(lane_q));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_write) && $stable(req_wdata) && $stable(req_tgt)));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (rst)
    pending |-> !req_valid);

endmodule

// File: rtl/lane_ovr_seq.sv
module lane_ovr_seq #(
  parameter int LANES           = 4,
  parameter int DATA_W          = 16,
  parameter int ADDR_W          = 16,
  parameter int MAX_EXTRA_POLLS = 1000,
  parameter int SETTLE_CYCLES   = 3000000,
  parameter int DPLL_MODE       = 3,
  localparam int LANE_W         = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              clear_cmd,
  input  logic [LANE_W-1:0] lane_sel,
  input  logic [3:0]        atten_val,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              done
);
  import lovr_pkg::*;

  tgt_e              tgt;
  logic [LANE_W-1:0] lane_q;
  logic              tmr_load;
  logic              tmr_zero;

  lovr_fsm #(
    .LANE_W(LANE_W), .DATA_W(DATA_W),
    .MAX_EXTRA_POLLS(MAX_EXTRA_POLLS), .DPLL_MODE(DPLL_MODE)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .start_cmd(start_cmd), .clear_cmd(clear_cmd),
    .lane_in(lane_sel), .atten_in(atten_val),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .req_tgt(tgt), .lane_q(lane_q), .busy(busy), .done(done)
  );

  lovr_addr #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_addr (
    .lane(lane_q), .tgt(tgt), .addr(req_addr)
  );

  lovr_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .zero(tmr_zero)
  );

  p_settle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !tmr_zero && !tmr_load && !req_valid) |=> !req_valid || tmr_zero);

endmodule

// File: tb/test_lane_ovr_seq.sv
module test_lane_ovr_seq;
  localparam int SETTLE = 40;
  localparam int LOGN   = 1200;

  typedef struct packed {
    logic        clr;
    logic        stall;
    logic [1:0]  lane;
    logic [3:0]  att;
    logic [15:0] rx;
    logic [15:0] tx;
    logic [10:0] hr;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 2'd0, 4'h5, 16'h4A5C, 16'h8123, 11'd0},
    '{1'b0, 1'b1, 2'd2, 4'h3, 16'h0F00, 16'h1C00, 11'd3},
    '{1'b0, 1'b0, 2'd3, 4'h8, 16'hFFFE, 16'h7777, 11'd0},
    '{1'b1, 1'b0, 2'd1, 4'h0, 16'hC0F0, 16'h0000, 11'd0},
    '{1'b0, 1'b1, 2'd1, 4'h7, 16'h0000, 16'h0000, 11'd1},
    '{1'b1, 1'b1, 2'd3, 4'hF, 16'h4002, 16'hFFFF, 11'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_cmd = 1'b0, clear_cmd = 1'b0;
  logic [1:0] lane_sel = '0;
  logic [3:0] atten_val = '0;
  logic req_valid, req_write, busy, done;
  logic [15:0] req_addr, req_wdata;
  logic req_ready = 1'b1;
  logic rsp_valid = 1'b0;
  logic [15:0] rsp_rdata = '0;

  int checks = 0, errors = 0;
  int cyc = 0;
  int log_n = 0;
  logic [15:0] lg_addr [LOGN];
  logic        lg_wr   [LOGN];
  logic [15:0] lg_data [LOGN];
  int          lg_cyc  [LOGN];
  logic [15:0] m_rx = '0, m_tx = '0;
  int hr_left = 0;
  bit stall_mode = 1'b0;
  int done_cnt = 0, done_cyc = 0;
  int hold_viol = 0;
  logic held = 1'b0;
  logic [15:0] held_addr, held_data;

  always #2.5 clk = ~clk;

  lane_ovr_seq #(.SETTLE_CYCLES(SETTLE)) i_lane_ovr_seq (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .clear_cmd(clear_cmd),
    .lane_sel(lane_sel), .atten_val(atten_val),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .busy(busy), .done(done)
  );

  // register access engine model
  always @(posedge clk) begin
    cyc = cyc + 1;
    rsp_valid <= 1'b0;
    req_ready <= stall_mode ? ~req_ready : 1'b1;
    if (held && (!req_valid || req_addr !== held_addr || req_wdata !== held_data))
      hold_viol = hold_viol + 1;
    held = 1'b0;
    if (req_valid && !req_ready) begin
      held = 1'b1; held_addr = req_addr; held_data = req_wdata;
    end
    if (req_valid && req_ready && !rst) begin
      logic [15:0] rv;
      rv = 16'h0;
      if (req_addr[7:0] == 8'h02) begin
        if (hr_left > 0) begin rv = m_rx | 16'h0001; hr_left = hr_left - 1; end
        else rv = m_rx & 16'hFFFE;
      end else if (req_addr[7:0] == 8'h01) rv = m_tx;
      if (log_n < LOGN) begin
        lg_addr[log_n] = req_addr;
        lg_wr[log_n]   = req_write;
        lg_data[log_n] = req_write ? req_wdata : rv;
        lg_cyc[log_n]  = cyc;
        log_n = log_n + 1;
      end
      if (!req_write) begin rsp_valid <= 1'b1; rsp_rdata <= rv; end
    end
  end

  always @(negedge clk) if (done) begin done_cnt = done_cnt + 1; done_cyc = cyc; end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(bit clr, bit both, logic [1:0] lane, logic [3:0] att,
                        logic [15:0] rx, logic [15:0] tx, int hr, bit stall, bit poke);
    int guard;
    @(negedge clk);
    m_rx = rx; m_tx = tx; hr_left = hr; stall_mode = stall;
    log_n = 0; done_cnt = 0; hold_viol = 0;
    lane_sel = lane; atten_val = att;
    start_cmd = !clr || both; clear_cmd = clr || both;
    @(negedge clk);
    start_cmd = 1'b0; clear_cmd = 1'b0;
    lane_sel = ~lane; atten_val = ~att;
    chk(busy === 1'b1, "R7 busy after command", {31'b0, busy}, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      start_cmd = 1'b1; clear_cmd = 1'b1; lane_sel = lane + 2'd1;
      @(negedge clk);
      start_cmd = 1'b0; clear_cmd = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (12) @(negedge clk);
    chk(hold_viol == 0, "R9 request held until accepted", hold_viol, 0);
  endtask

  task automatic check_start(logic [1:0] lane, logic [3:0] att, int hr);
    logic [15:0] rxs, rxo, txs, txo, r, t;
    logic [15:0] w [5];
    logic [15:0] v [3];
    int npoll, k, p;
    rxs = 16'h2002 + 16'(lane) * 16'h100;
    rxo = 16'h2005 + 16'(lane) * 16'h100;
    txs = 16'h2001 + 16'(lane) * 16'h100;
    txo = 16'h2004 + 16'(lane) * 16'h100;
    npoll = (hr >= 1000) ? 1001 : hr + 1;
    k = 0;
    while (k < log_n && !lg_wr[k] && lg_addr[k] == rxs) k++;
    chk(k == npoll + 1, "R2 RX status reads (polls plus one)", k, npoll + 1);
    r = lg_data[npoll];
    w[0] = r & ~16'h4000;
    w[1] = w[0] | 16'h4000;
    w[2] = (w[1] & ~16'h0700) | 16'h0300;
    w[3] = w[2] | 16'h0800;
    w[4] = w[3] & ~16'h0800;
    for (int i = 0; i < 5; i++) begin
      chk(lg_wr[npoll+1+i] === 1'b1 && lg_addr[npoll+1+i] === rxo,
          "R3 RX override write address", lg_addr[npoll+1+i], rxo);
      chk(lg_data[npoll+1+i] === w[i], "R3 RX override write data",
          lg_data[npoll+1+i], w[i]);
    end
    p = npoll + 6;
    if (!att[3]) begin
      chk(lg_wr[p] === 1'b0 && lg_addr[p] === txs, "R5 TX status read", lg_addr[p], txs);
      chk(lg_cyc[p] - lg_cyc[p-1] >= SETTLE && lg_cyc[p] - lg_cyc[p-1] <= SETTLE + 6,
          "R4 settle gap", lg_cyc[p] - lg_cyc[p-1], SETTLE);
      t = lg_data[p];
      v[0] = t & ~16'h8000;
      v[1] = v[0] | 16'h8000;
      v[2] = v[1] | (16'(att[2:0]) << 10);
      for (int i = 0; i < 3; i++) begin
        chk(lg_wr[p+1+i] === 1'b1 && lg_addr[p+1+i] === txo,
            "R5 TX override write address", lg_addr[p+1+i], txo);
        chk(lg_data[p+1+i] === v[i], "R5 TX override write data", lg_data[p+1+i], v[i]);
      end
      chk(log_n == p + 4, "R5 access count", log_n, p + 4);
      chk(done_cyc == lg_cyc[p+3], "R7 done after final write", done_cyc, lg_cyc[p+3]);
    end else begin
      chk(log_n == p, "R5 skip leaves TX untouched", log_n, p);
      chk(done_cyc - lg_cyc[p-1] >= SETTLE, "R4 done after settle",
          done_cyc - lg_cyc[p-1], SETTLE);
    end
    chk(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
  endtask

  task automatic check_clear(logic [1:0] lane);
    logic [15:0] rxs, rxo;
    rxs = 16'h2002 + 16'(lane) * 16'h100;
    rxo = 16'h2005 + 16'(lane) * 16'h100;
    chk(log_n == 2, "R6 clear makes two accesses", log_n, 2);
    chk(lg_wr[0] === 1'b0 && lg_addr[0] === rxs, "R6 clear read", lg_addr[0], rxs);
    chk(lg_wr[1] === 1'b1 && lg_addr[1] === rxo, "R6 clear write address", lg_addr[1], rxo);
    chk(lg_data[1] === (lg_data[0] & ~16'h4000), "R6 clear write data",
        lg_data[1], lg_data[0] & ~16'h4000);
    chk(done_cnt == 1 && done_cyc == lg_cyc[1], "R7 clear done timing", done_cyc, lg_cyc[1]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && req_valid === 1'b0, "R1 outputs in reset",
        {busy, done, req_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && req_valid === 1'b0, "R1 outputs after reset",
        {busy, done, req_valid}, 0);

    foreach (VECS[i]) begin
      run_op(VECS[i].clr, 1'b0, VECS[i].lane, VECS[i].att, VECS[i].rx, VECS[i].tx,
             int'(VECS[i].hr), VECS[i].stall, 1'b0);
      if (VECS[i].clr) check_clear(VECS[i].lane);
      else check_start(VECS[i].lane, VECS[i].att, int'(VECS[i].hr));
    end

    // R2 bound: half-rate never drops within the poll limit
    run_op(1'b0, 1'b0, 2'd0, 4'h2, 16'h1234, 16'h0040, 1500, 1'b0, 1'b0);
    check_start(2'd0, 4'h2, 1500);
    chk(lg_data[1001][0] === 1'b1, "R2 last read still half-rate", lg_data[1001][0], 1);

    // R2 boundary: exactly 1000 extra polls needed
    run_op(1'b0, 1'b0, 2'd1, 4'h8, 16'h0010, 16'h0, 1000, 1'b0, 1'b0);
    check_start(2'd1, 4'h8, 1000);

    // R8: commands during busy ignored, with engine stalls
    run_op(1'b0, 1'b0, 2'd2, 4'h6, 16'hA5A4, 16'h5A5A, 2, 1'b1, 1'b1);
    check_start(2'd2, 4'h6, 2);

    // R8: start wins over clear
    run_op(1'b0, 1'b1, 2'd3, 4'h1, 16'h3300, 16'hC3C3, 0, 1'b0, 1'b0);
    check_start(2'd3, 4'h1, 0);

    // R8: clear during busy also ignored
    run_op(1'b1, 1'b0, 2'd0, 4'h0, 16'hFFFF, 16'h0, 0, 1'b1, 1'b1);
    check_clear(2'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule